// File: doc/BRIEF.md
# Registered Multiply-Accumulate Unit

This block multiplies two 16-bit operands and folds the full 32-bit product into a 35-bit accumulator. The operands are either two's complement or unsigned. A mode bit picks the format for each multiply. The accumulator can take a fresh product, add the product to what it holds, or subtract the product from it. It can also be loaded directly from its own output pins.

The operands, the mode controls and the result each sit in a register. Each register captures on a rising clock edge, but only when its own capture enable is high. The result is split into three fields:
- a 3-bit extension, which absorbs growth across repeated accumulations;
- a 16-bit high word;
- a 16-bit low word.

The extension and the high word have their own bidirectional three-state ports. The low word shares the pins that carry the Y operand in. Each field has an output enable. With its enable low, a field's pins are released so that outside logic can drive them. That is how a preload value reaches the accumulator, and how Y operands reach the block.

Top module: `mac16_acc`

## Requirements
- R1: During and after reset, every field of the result reads zero.
- R2: The X register takes `x_in` on a rising edge with `x_cap` high, and the Y register takes the shared low-word bus on a rising edge with `y_cap` high. Otherwise each holds its value, so a later multiply reuses the held operand.
- R3: `twos_mode`=1 treats both operands as two's complement and `twos_mode`=0 as unsigned. The mode is captured only on an edge where `x_cap` or `y_cap` is high.
- R4: On a result capture with `acc_mode`=0 and `preload`=0, the result becomes the extended product of the held operands, whatever `sub_mode` is.
- R5: On a result capture with `acc_mode`=1, `sub_mode`=0 and `preload`=0, the result becomes the old result plus the extended product, modulo 2^35.
- R6: On a result capture with `acc_mode`=1, `sub_mode`=1 and `preload`=0, the result becomes the old result minus the extended product, modulo 2^35.
- R7: The product is sign-extended to 35 bits in two's complement mode and zero-extended in unsigned mode. Repeated additions carry into the extension field.
- R8: On a result capture with `preload`=1, the result loads the value present on the pins: extension from `ext_io`, high word from `msw_io`, low word from `y_lsw_io`. `acc_mode` and `sub_mode` have no effect.
- R9: With `res_cap` low, the result holds its value.
- R10: A field is driven on its port only while its output enable is high; with the enable low, a value driven from outside is read back unchanged.
- R11: `acc_mode` and `sub_mode` are captured together with the operands, on an edge with `x_cap` or `y_cap` high. A change to them on a later cycle without a capture does not alter the next accumulate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_cap | input | 1 | Capture enable for X and mode controls |
| y_cap | input | 1 | Capture enable for Y and mode controls |
| res_cap | input | 1 | Capture enable for the result register |
| twos_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| acc_mode | input | 1 | 1 = accumulate, 0 = load product |
| sub_mode | input | 1 | With accumulate: 1 = subtract, 0 = add |
| preload | input | 1 | Load the result from the pins on result capture |
| oe_ext | input | 1 | Output enable of the extension field |
| oe_msw | input | 1 | Output enable of the high word |
| oe_lsw | input | 1 | Output enable of the low word |
| x_in | input | 16 | X operand |
| y_lsw_io | inout | 16 | Y operand in, low result word out |
| msw_io | inout | 16 | High result word, preload input |
| ext_io | inout | 3 | Extension field, preload input |

## Verification
The bench targets three corner cases:
- **Full-scale negative square.** The signed product of -32768 by -32768 is +2^30. A design that drops the sign-extension bit, or multiplies only the low 16-bit magnitudes, gives a negative or truncated result.
- **Long accumulation chains.** Chains of subtractions drive the accumulator below zero, so the extension field must fill with ones. Chains of unsigned full-scale additions grow into the extension and then wrap, which exposes a product that is sign-extended in unsigned mode or an accumulator that saturates.
- **Late control changes and preload.** Every multiply flips the mode and accumulate controls one cycle after capture, so any design that reads them live rather than from the capture register takes the wrong path. Preload and released-bus checks catch a field that keeps driving its pins or ignores the value driven onto them.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W_DEF  = 16;
    localparam int EXT_W_DEF = 3;

    typedef enum logic [2:0] {
        ACC_HOLD    = 3'd0,
        ACC_PRELOAD = 3'd1,
        ACC_LOAD    = 3'd2,
        ACC_ADD     = 3'd3,
        ACC_SUB     = 3'd4
    } acc_op_e;

    // Priority: no capture, then preload, then load, then subtract / add.
    function automatic acc_op_e pick_op(input logic cap, input logic pre,
                                        input logic acc, input logic sub);
        if (!cap)      return ACC_HOLD;
        else if (pre)  return ACC_PRELOAD;
        else if (!acc) return ACC_LOAD;
        else if (sub)  return ACC_SUB;
        else           return ACC_ADD;
    endfunction

endpackage

// File: rtl/mac_operand_stage.sv
module mac_operand_stage #(
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            x_cap,
    input  logic            y_cap,
    input  logic [OP_W-1:0] x_in,
    input  logic [OP_W-1:0] y_in,
    input  logic            twos_in,
    input  logic            acc_in,
    input  logic            sub_in,
    output logic [OP_W-1:0] x_q,
    output logic [OP_W-1:0] y_q,
    output logic            twos_q,
    output logic            acc_q,
    output logic            sub_q
);

    typedef struct packed {
        logic [OP_W-1:0] x;
        logic [OP_W-1:0] y;
        logic            twos;
        logic            acc;
        logic            sub;
    } opnd_t;

    opnd_t opnd_d, opnd_q;

    always_comb begin
        opnd_d = opnd_q;
        if (x_cap) opnd_d.x = x_in;
        if (y_cap) opnd_d.y = y_in;
        // Controls travel with whichever operand is captured.
        if (x_cap || y_cap) begin
            opnd_d.twos = twos_in;
            opnd_d.acc  = acc_in;
            opnd_d.sub  = sub_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) opnd_q <= '0;
        else        opnd_q <= opnd_d;
    end

    assign x_q    = opnd_q.x;
    assign y_q    = opnd_q.y;
    assign twos_q = opnd_q.twos;
    assign acc_q  = opnd_q.acc;
    assign sub_q  = opnd_q.sub;

    a_r2_x_held: assert property (@(posedge clk) disable iff (!rst_n)
        !x_cap |=> $stable(x_q));
    a_r2_y_held: assert property (@(posedge clk) disable iff (!rst_n)
        !y_cap |=> $stable(y_q));
    a_r11_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_cap || y_cap) |=> $stable({twos_q, acc_q, sub_q}));

endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 35
) (
    input  logic [OP_W-1:0]  x,
    input  logic [OP_W-1:0]  y,
    input  logic             twos,
    output logic [ACC_W-1:0] prod
);

    localparam int OPX_W  = OP_W + 1;
    localparam int FULL_W = 2 * OPX_W;

    logic signed [OPX_W-1:0]  xs, ys;
    logic signed [FULL_W-1:0] full;

    // One extra bit per operand: the sign in two's complement mode, zero
    // in unsigned mode, so a single signed multiplier serves both formats.
    always_comb begin
        xs   = $signed({twos & x[OP_W-1], x});
        ys   = $signed({twos & y[OP_W-1], y});
        full = FULL_W'(xs) * FULL_W'(ys);
        prod = ACC_W'(full);
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int ACC_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_cap,
    input  logic             preload,
    input  logic             acc_q,
    input  logic             sub_q,
    input  logic             twos_q,
    input  logic [ACC_W-1:0] prod,
    input  logic [ACC_W-1:0] pl_word,
    output logic [ACC_W-1:0] res_q
);
    import mac_pkg::*;

    typedef struct packed {
        logic [ACC_W-1:0] res;
    } acc_t;

    acc_t    acc_d, acc_st_q;
    acc_op_e op;

    always_comb begin
        acc_d = acc_st_q;
        op    = pick_op(res_cap, preload, acc_q, sub_q);
        case (op)
            ACC_PRELOAD: acc_d.res = pl_word;
            ACC_LOAD:    acc_d.res = prod;
            ACC_ADD:     acc_d.res = acc_st_q.res + prod;
            ACC_SUB:     acc_d.res = acc_st_q.res - prod;
            default:     acc_d.res = acc_st_q.res;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_st_q <= '0;
        else        acc_st_q <= acc_d;
    end

    assign res_q = acc_st_q.res;

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_cap |=> $stable(res_q));
    a_r8_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (res_cap && preload) |=> res_q == $past(pl_word));
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (res_cap && !preload && !acc_q) |=> res_q == $past(prod));
    a_r5_add: assert property (@(posedge clk) disable iff (!rst_n)
        (res_cap && !preload && acc_q && !sub_q) |=>
        (res_q - $past(prod)) == $past(res_q));
    a_r6_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (res_cap && !preload && acc_q && sub_q) |=>
        (res_q + $past(prod)) == $past(res_q));
    a_r7_unsigned_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !twos_q |-> prod[ACC_W-1] == 1'b0);

endmodule

// File: rtl/mac16_acc.sv
module mac16_acc #(
    parameter int OP_W  = mac_pkg::OP_W_DEF,
    parameter int EXT_W = mac_pkg::EXT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_cap,
    input  logic             y_cap,
    input  logic             res_cap,
    input  logic             twos_mode,
    input  logic             acc_mode,
    input  logic             sub_mode,
    input  logic             preload,
    input  logic             oe_ext,
    input  logic             oe_msw,
    input  logic             oe_lsw,
    input  logic [OP_W-1:0]  x_in,
    inout  wire  [OP_W-1:0]  y_lsw_io,
    inout  wire  [OP_W-1:0]  msw_io,
    inout  wire  [EXT_W-1:0] ext_io
);

    localparam int ACC_W = 2 * OP_W + EXT_W;

    logic [OP_W-1:0]  x_q, y_q;
    logic             twos_q, acc_q, sub_q;
    logic [ACC_W-1:0] prod, res_q, pl_word;

    mac_operand_stage #(.OP_W(OP_W)) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_cap   (x_cap),
        .y_cap   (y_cap),
        .x_in    (x_in),
        .y_in    (y_lsw_io),
        .twos_in (twos_mode),
        .acc_in  (acc_mode),
        .sub_in  (sub_mode),
        .x_q     (x_q),
        .y_q     (y_q),
        .twos_q  (twos_q),
        .acc_q   (acc_q),
        .sub_q   (sub_q)
    );

    mac_multiplier #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
        .x    (x_q),
        .y    (y_q),
        .twos (twos_q),
        .prod (prod)
    );

    assign pl_word = {ext_io, msw_io, y_lsw_io};

    mac_accum #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .res_cap (res_cap),
        .preload (preload),
        .acc_q   (acc_q),
        .sub_q   (sub_q),
        .twos_q  (twos_q),
        .prod    (prod),
        .pl_word (pl_word),
        .res_q   (res_q)
    );

    assign ext_io   = oe_ext ? res_q[ACC_W-1 -: EXT_W]  : {EXT_W{1'bz}};
    assign msw_io   = oe_msw ? res_q[2*OP_W-1 -: OP_W]  : {OP_W{1'bz}};
    assign y_lsw_io = oe_lsw ? res_q[OP_W-1:0]          : {OP_W{1'bz}};

endmodule

// File: tb/mac16_acc_tb.sv
`timescale 1ns/1ps
module mac16_acc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_cap = 0, y_cap = 0, res_cap = 0;
    logic        twos_mode = 0, acc_mode = 0, sub_mode = 0, preload = 0;
    logic        oe_ext = 1, oe_msw = 1, oe_lsw = 1;
    logic [15:0] x_in = '0;
    logic [15:0] tb_y = '0, tb_msw = '0;
    logic [2:0]  tb_ext = '0;
    logic        tb_y_en = 0, tb_msw_en = 0, tb_ext_en = 0;

    wire  [15:0] y_lsw_io, msw_io;
    wire  [2:0]  ext_io;

    assign y_lsw_io = tb_y_en   ? tb_y   : 16'hzzzz;
    assign msw_io   = tb_msw_en ? tb_msw : 16'hzzzz;
    assign ext_io   = tb_ext_en ? tb_ext : 3'bzzz;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    mac16_acc u_dut (
        .clk(clk), .rst_n(rst_n), .x_cap(x_cap), .y_cap(y_cap),
        .res_cap(res_cap), .twos_mode(twos_mode), .acc_mode(acc_mode),
        .sub_mode(sub_mode), .preload(preload), .oe_ext(oe_ext),
        .oe_msw(oe_msw), .oe_lsw(oe_lsw), .x_in(x_in),
        .y_lsw_io(y_lsw_io), .msw_io(msw_io), .ext_io(ext_io)
    );

    // Behavioural reference model
    logic [15:0] m_x, m_y;
    logic        m_tc, m_acc, m_sub;
    logic [34:0] m_res;

    function automatic logic [34:0] ref_prod(logic [15:0] a, logic [15:0] b, logic tc);
        longint p;
        if (tc) p = longint'($signed(a)) * longint'($signed(b));
        else    p = longint'(a) * longint'(b);
        return p[34:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_x <= '0; m_y <= '0; m_tc <= 0; m_acc <= 0; m_sub <= 0; m_res <= '0;
        end else begin
            logic [15:0] ybus;
            logic [34:0] pin;
            ybus = tb_y_en ? tb_y : m_res[15:0];
            pin  = {oe_ext ? m_res[34:32] : tb_ext,
                    oe_msw ? m_res[31:16] : tb_msw,
                    oe_lsw ? m_res[15:0]  : tb_y};
            if (res_cap) begin
                if (preload)      m_res <= pin;
                else if (!m_acc)  m_res <= ref_prod(m_x, m_y, m_tc);
                else if (m_sub)   m_res <= m_res - ref_prod(m_x, m_y, m_tc);
                else              m_res <= m_res + ref_prod(m_x, m_y, m_tc);
            end
            if (x_cap) m_x <= x_in;
            if (y_cap) m_y <= ybus;
            if (x_cap || y_cap) begin
                m_tc <= twos_mode; m_acc <= acc_mode; m_sub <= sub_mode;
            end
        end
    end

    task automatic check_val(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Wait for the falling edge and compare every driven field with the model.
    task automatic step();
        @(negedge clk);
        if (oe_ext) check_val(cur_tag, "ext", {13'b0, ext_io}, {13'b0, m_res[34:32]});
        if (oe_msw) check_val(cur_tag, "msw", msw_io, m_res[31:16]);
        if (oe_lsw && !tb_y_en) check_val(cur_tag, "lsw", y_lsw_io, m_res[15:0]);
    endtask

    // Two-cycle operation; controls are flipped in the second cycle (R11).
    task automatic op(logic [15:0] x, logic [15:0] y, logic tc, logic acc,
                      logic sub, string tag);
        step();
        cur_tag = tag;
        oe_lsw = 0; tb_y_en = 1; tb_y = y; x_in = x;
        x_cap = 1; y_cap = 1; res_cap = 0; preload = 0;
        twos_mode = tc; acc_mode = acc; sub_mode = sub;
        step();
        tb_y_en = 0; oe_lsw = 1; x_cap = 0; y_cap = 0; res_cap = 1;
        twos_mode = ~tc; acc_mode = ~acc; sub_mode = ~sub;
        x_in = ~x;
    endtask

    task automatic idle(string tag);
        step();
        cur_tag = tag;
        res_cap = 0; x_cap = 0; y_cap = 0; preload = 0;
    endtask

    function automatic logic [15:0] pick16();
        case ($urandom_range(0, 5))
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        cur_tag = "R1";
        step();
        idle("R1");

        // R4 R7: unsigned full scale, sub ignored on load
        op(16'hFFFF, 16'hFFFF, 0, 0, 1, "R4");
        idle("R4");
        op(16'hFFFF, 16'hFFFF, 1, 0, 0, "R7");
        idle("R7");
        op(16'hFFFF, 16'h0001, 1, 0, 0, "R7");
        idle("R7");
        // R3: largest negative squared
        op(16'h8000, 16'h8000, 1, 0, 0, "R3");
        idle("R3");
        op(16'h8000, 16'h8000, 0, 0, 0, "R3");
        idle("R3");

        // R5 R7: unsigned growth into the extension, then wrap
        op(16'hFFFF, 16'hFFFF, 0, 0, 0, "R5");
        for (int i = 0; i < 8; i++) op(16'hFFFF, 16'hFFFF, 0, 1, 0, "R7");
        idle("R5");

        // R6: chained subtraction into negative values
        op(16'h0003, 16'h0004, 1, 0, 0, "R6");
        for (int i = 0; i < 5; i++) op(16'h7FFF, 16'h7FFF, 1, 1, 1, "R6");
        op(16'h8000, 16'h7FFF, 1, 1, 1, "R6");
        idle("R6");

        // R9 R2: result holds; a later capture reuses held operands
        op(16'h1234, 16'h5678, 0, 0, 0, "R2");
        idle("R9");
        for (int i = 0; i < 3; i++) begin
            step();
            x_in = 16'($urandom);
        end
        step();
        cur_tag = "R2";
        res_cap = 1;
        idle("R2");

        // R10 R8: released pins, external drive, preload
        step();
        cur_tag = "R10";
        oe_ext = 0; oe_msw = 0; oe_lsw = 0;
        tb_ext_en = 1; tb_msw_en = 1; tb_y_en = 1;
        tb_ext = 3'b101; tb_msw = 16'h1234; tb_y = 16'hABCD;
        preload = 1; res_cap = 1; acc_mode = 1; sub_mode = 1;
        @(negedge clk);
        check_val("R10", "ext released", {13'b0, ext_io}, 16'h0005);
        check_val("R10", "msw released", msw_io, 16'h1234);
        check_val("R10", "lsw released", y_lsw_io, 16'hABCD);
        preload = 0; res_cap = 0;
        tb_ext_en = 0; tb_msw_en = 0; tb_y_en = 0;
        oe_ext = 1; oe_msw = 1; oe_lsw = 1;
        cur_tag = "R8";
        step();
        check_val("R8", "preload ext", {13'b0, ext_io}, 16'h0005);
        check_val("R8", "preload msw", msw_io, 16'h1234);
        check_val("R8", "preload lsw", y_lsw_io, 16'hABCD);
        op(16'h0002, 16'h0003, 0, 1, 0, "R8");
        idle("R8");
        step();
        check_val("R5", "add after preload lsw", y_lsw_io, 16'hABD3);

        // R11: controls change after capture (inside op) must not matter
        op(16'h0010, 16'h0010, 0, 1, 0, "R11");
        idle("R11");

        // Random mix of formats and operations
        for (int i = 0; i < 300; i++)
            op(pick16(), pick16(), 1'($urandom), 1'($urandom), 1'($urandom), "R5");
        idle("R6");
        step();
        step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule